// File: doc/BRIEF.md
# Power Mode and Wake-Up Controller

This block governs the operating modes of a small microcontroller. Software programs two 8-bit control registers. From them the block switches the fast and slow oscillators on or off and selects which one clocks the system. It can also halt the processor in one of three ways. The light sleep keeps peripherals clocked. The timer-only sleep leaves just the time-base timer running. The deep stop shuts down everything, including both oscillators.

Deep stop ends on a wake pin, either on a falling edge or on a high level. After that, a programmable warm-up count runs in the clock domain the block is returning to, and only then does the processor resume. Port pins are either tri-stated or held during deep stop. An oscillator setting that would leave the system without a clock is refused, and the block raises a one-cycle reset request instead. Oscillators, interrupts and the processor are modelled as plain inputs and outputs. The fast and slow clock domains appear as tick enables on one clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, register A (select 0) reads 0x00 and register B (select 1) reads 0x80. The processor runs, the fast oscillator is enabled, the slow oscillator is disabled, the slow clock is not selected, and the reset request is low.
- R2: Register A holds stop request (bit 7), level wake mode (bit 6), return to slow (bit 5), keep port outputs (bit 4) and warm-up code (bits 3:2). Register B holds fast oscillator on (bit 7), slow oscillator on (bit 6), clock select (bit 5, 1 = slow; on read it gives the clock in use), light sleep (bit 4) and timer-only sleep (bit 2). All other bits read 0.
- R3: Writing A with bit 7 = 1 enters deep stop. The processor, peripheral and time-base clocks are all off, both oscillators are disabled, and A bit 7 reads 1.
- R4: With A bit 6 = 0, only a falling edge of the wake pin ends deep stop. A rising edge or a steady high level does not.
- R5: With A bit 6 = 1, a high level on the wake pin ends deep stop, and the block always returns to the fast clock whatever A bit 5 holds.
- R6: With A bit 6 = 0, the return clock is slow when A bit 5 = 1 and fast when it is 0. On return, the clock select output and B bit 5 show that clock, and B bit 7 or bit 6 (whichever matches the return clock) reads 1.
- R7: Warm-up length N = M × 2^S ticks of the return domain. M is 3 when A bit 2 = 0 and 1 when it is 1. S is the high or low shift parameter of that domain, chosen by A bit 3 = 0 or 1. Counting the edge that samples the wake condition as edge 1, the processor runs again after edge N+3 plus one edge per missing tick. Ticks of the other domain count nothing. A bit 7 reads 0 after return.
- R8: During deep stop and warm-up, the tri-state output equals NOT A bit 4 and the hold output equals A bit 4. Outside those phases both are 0.
- R9: A write to B that would give both oscillators off, the fast one off with bit 5 = 0, or the slow one off with bit 5 = 1 is discarded. Both registers return to their reset values, and the reset request is high for exactly the cycle after the write.
- R10: Writing B bit 4 = 1 halts the processor while keeping peripheral and time-base clocks. An interrupt wakes it at the next edge and B bit 4 then reads 0.
- R11: Writing B bit 2 = 1 halts the processor and the peripheral clocks but keeps the time-base clock. An interrupt wakes it at the next edge and B bit 2 then reads 0.
- R12: A write setting both B bit 4 and bit 2 gives light sleep only, and B bit 2 reads 0.
- R13: Register writes are taken only while the processor runs. Writes presented in any halted mode leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = A, 1 = B |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read select: 0 = A, 1 = B |
| rd_data_o | output | 8 | Read data |
| fast_tick_i | input | 1 | Fast clock domain tick |
| slow_tick_i | input | 1 | Slow clock domain tick |
| wake_pin_i | input | 1 | Deep-stop wake pin |
| irq_i | input | 1 | Enabled interrupt pending |
| cpu_run_o | output | 1 | Processor and watchdog clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| tbt_clk_en_o | output | 1 | Time-base timer clock enable |
| port_hiz_o | output | 1 | Tri-state general ports (wake pin excluded) |
| port_hold_o | output | 1 | Hold general port outputs |
| fast_osc_en_o | output | 1 | Fast oscillator enable |
| slow_osc_en_o | output | 1 | Slow oscillator enable |
| sys_clk_slow_o | output | 1 | Slow clock in use |
| rst_req_o | output | 1 | Internal reset request |

## Verification
The bench sweeps all four warm-up codes across three stop configurations: edge wake returning fast, edge wake returning slow, and level wake with the slow-return bit set. The cycle count to resume must match the computed length for each case. In every run the slow ticks are withheld for three edges. That delays only a slow return, so a count taken from the wrong domain shows up. Before each wake, a rising edge or low level is applied to show that the wrong wake polarity is ignored. The three illegal oscillator writes, each next to a legal neighbour, and the two sleep modes with their combined write separate the reset, gating and priority rules.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_TGH, ST_STOP, ST_WARM, ST_DONE
  } pmc_state_e;

  // register A fields
  localparam int A_STOP  = 7;
  localparam int A_LVL   = 6;
  localparam int A_RSLOW = 5;
  localparam int A_KEEP  = 4;
  localparam int A_WU_HI = 3;
  localparam int A_WU_LO = 2;
  // register B fields
  localparam int B_FON   = 7;
  localparam int B_SON   = 6;
  localparam int B_CSEL  = 5;
  localparam int B_NAP   = 4;
  localparam int B_TGNAP = 2;
endpackage

// File: rtl/pmc_wake_det.sv
module pmc_wake_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic level_mode_i,
  output logic release_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign release_o = level_mode_i ? pin_i : (pin_q & ~pin_i);
endmodule

// File: rtl/pmc_osc_check.sv
module pmc_osc_check (
  input  logic fast_on_i,
  input  logic slow_on_i,
  input  logic clk_slow_i,
  output logic illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    if (!fast_on_i && !slow_on_i)  illegal_o = 1'b1;
    if (!fast_on_i && !clk_slow_i) illegal_o = 1'b1;
    if (!slow_on_i && clk_slow_i)  illegal_o = 1'b1;
  end
endmodule

// File: rtl/pmc_warmup.sv
module pmc_warmup #(
  parameter int FAST_SH_HI = 16,
  parameter int FAST_SH_LO = 14,
  parameter int SLOW_SH_HI = 13,
  parameter int SLOW_SH_LO = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       active_i,
  input  logic       slow_i,
  input  logic [1:0] code_i,
  input  logic       fast_tick_i,
  input  logic       slow_tick_i,
  output logic       zero_o
);
  localparam int MAX_F = (FAST_SH_HI > FAST_SH_LO) ? FAST_SH_HI : FAST_SH_LO;
  localparam int MAX_S = (SLOW_SH_HI > SLOW_SH_LO) ? SLOW_SH_HI : SLOW_SH_LO;
  localparam int MAX_SH = (MAX_F > MAX_S) ? MAX_F : MAX_S;
  localparam int CW = MAX_SH + 2;

  logic [CW-1:0] cnt_q;
  logic          tick;

  function automatic logic [CW-1:0] warm_len(input logic slow, input logic [1:0] code);
    int sh;
    logic [CW-1:0] base;
    if (slow) sh = code[1] ? SLOW_SH_LO : SLOW_SH_HI;
    else      sh = code[1] ? FAST_SH_LO : FAST_SH_HI;
    base = code[0] ? CW'(1) : CW'(3);
    return base << sh;
  endfunction

  assign tick = slow_i ? slow_tick_i : fast_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (load_i)                            cnt_q <= warm_len(slow_i, code_i);
    else if (active_i && tick && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // count only moves on a tick of the selected domain
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick && !load_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int FAST_SH_HI = 16,
  parameter int FAST_SH_LO = 14,
  parameter int SLOW_SH_HI = 13,
  parameter int SLOW_SH_LO = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  input  logic       fast_tick_i,
  input  logic       slow_tick_i,
  input  logic       wake_pin_i,
  input  logic       irq_i,
  output logic       cpu_run_o,
  output logic       periph_clk_en_o,
  output logic       tbt_clk_en_o,
  output logic       port_hiz_o,
  output logic       port_hold_o,
  output logic       fast_osc_en_o,
  output logic       slow_osc_en_o,
  output logic       sys_clk_slow_o,
  output logic       rst_req_o
);
  pmc_state_e state_q;
  logic       stop_q, wake_lvl_q, ret_slow_q, keep_out_q;
  logic [1:0] wu_code_q;
  logic       fast_on_q, slow_on_q, clk_slow_q, nap_q, tg_nap_q;
  logic       rst_req_q;
  logic       running, wr_a, wr_b, illegal, wake_rel, warm_zero, tgt_slow, in_stop;
  logic       unused_bits;

  assign unused_bits = ^{wr_data_i[3], wr_data_i[1:0]};
  assign running  = (state_q == ST_RUN);
  assign wr_a     = wr_en_i & ~wr_sel_i & running;
  assign wr_b     = wr_en_i &  wr_sel_i & running;
  assign tgt_slow = ~wake_lvl_q & ret_slow_q;  // level wake forces fast return
  assign in_stop  = (state_q == ST_STOP) || (state_q == ST_WARM);

  pmc_osc_check u_osc_check (
    .fast_on_i (wr_data_i[B_FON]),
    .slow_on_i (wr_data_i[B_SON]),
    .clk_slow_i(wr_data_i[B_CSEL]),
    .illegal_o (illegal)
  );

  pmc_wake_det u_wake_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (wake_pin_i),
    .level_mode_i(wake_lvl_q),
    .release_o   (wake_rel)
  );

  pmc_warmup #(
    .FAST_SH_HI(FAST_SH_HI), .FAST_SH_LO(FAST_SH_LO),
    .SLOW_SH_HI(SLOW_SH_HI), .SLOW_SH_LO(SLOW_SH_LO)
  ) u_warmup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     ((state_q == ST_STOP) && wake_rel),
    .active_i   (state_q == ST_WARM),
    .slow_i     (tgt_slow),
    .code_i     (wu_code_q),
    .fast_tick_i(fast_tick_i),
    .slow_tick_i(slow_tick_i),
    .zero_o     (warm_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      stop_q     <= 1'b0;
      wake_lvl_q <= 1'b0;
      ret_slow_q <= 1'b0;
      keep_out_q <= 1'b0;
      wu_code_q  <= 2'b00;
      fast_on_q  <= 1'b1;
      slow_on_q  <= 1'b0;
      clk_slow_q <= 1'b0;
      nap_q      <= 1'b0;
      tg_nap_q   <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      rst_req_q <= wr_b & illegal;
      unique case (state_q)
        ST_RUN: begin
          if (wr_b && illegal) begin
            stop_q     <= 1'b0;
            wake_lvl_q <= 1'b0;
            ret_slow_q <= 1'b0;
            keep_out_q <= 1'b0;
            wu_code_q  <= 2'b00;
            fast_on_q  <= 1'b1;
            slow_on_q  <= 1'b0;
            clk_slow_q <= 1'b0;
            nap_q      <= 1'b0;
            tg_nap_q   <= 1'b0;
          end else if (wr_b) begin
            fast_on_q  <= wr_data_i[B_FON];
            slow_on_q  <= wr_data_i[B_SON];
            clk_slow_q <= wr_data_i[B_CSEL];
            nap_q      <= wr_data_i[B_NAP];
            tg_nap_q   <= wr_data_i[B_TGNAP] & ~wr_data_i[B_NAP];
            if (wr_data_i[B_NAP])        state_q <= ST_IDLE;
            else if (wr_data_i[B_TGNAP]) state_q <= ST_TGH;
          end else if (wr_a) begin
            stop_q     <= wr_data_i[A_STOP];
            wake_lvl_q <= wr_data_i[A_LVL];
            ret_slow_q <= wr_data_i[A_RSLOW];
            keep_out_q <= wr_data_i[A_KEEP];
            wu_code_q  <= wr_data_i[A_WU_HI:A_WU_LO];
            if (wr_data_i[A_STOP]) state_q <= ST_STOP;
          end
        end
        ST_IDLE: if (irq_i) begin
          nap_q   <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_TGH: if (irq_i) begin
          tg_nap_q <= 1'b0;
          state_q  <= ST_RUN;
        end
        ST_STOP: if (wake_rel) state_q <= ST_WARM;
        ST_WARM: if (warm_zero) begin
          stop_q     <= 1'b0;
          clk_slow_q <= tgt_slow;
          if (tgt_slow) slow_on_q <= 1'b1;
          else          fast_on_q <= 1'b1;
          state_q    <= ST_DONE;
        end
        ST_DONE: state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    if (rd_sel_i)
      rd_data_o = {fast_on_q, slow_on_q, clk_slow_q, nap_q, 1'b0, tg_nap_q, 2'b00};
    else
      rd_data_o = {stop_q, wake_lvl_q, ret_slow_q, keep_out_q, wu_code_q, 2'b00};
  end

  assign cpu_run_o       = running;
  assign periph_clk_en_o = running || (state_q == ST_IDLE);
  assign tbt_clk_en_o    = running || (state_q == ST_IDLE) || (state_q == ST_TGH);
  assign port_hiz_o      = in_stop & ~keep_out_q;
  assign port_hold_o     = in_stop & keep_out_q;
  assign sys_clk_slow_o  = clk_slow_q;
  assign rst_req_o       = rst_req_q;

  always_comb begin
    if (state_q == ST_STOP) begin
      fast_osc_en_o = 1'b0;
      slow_osc_en_o = 1'b0;
    end else if (state_q == ST_WARM) begin
      fast_osc_en_o = ~tgt_slow;
      slow_osc_en_o = tgt_slow;
    end else begin
      fast_osc_en_o = fast_on_q;
      slow_osc_en_o = slow_on_q;
    end
  end

  p_stop_dark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (!fast_osc_en_o && !slow_osc_en_o && !tbt_clk_en_o));
  p_done_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> cpu_run_o);
  p_level_fast_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && wake_lvl_q) |-> !sys_clk_slow_o);
  p_rst_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_nap_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && irq_i) |=> cpu_run_o);
  p_nap_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nap_q && tg_nap_q));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int FH = 4, FL = 2, SH = 3, SL = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic fast_tick = 1, slow_tick = 1, wake = 1, irq = 0;
  logic cpu_run, periph_en, tbt_en, hiz, hold, fosc, sosc, clk_slow, rst_req;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.FAST_SH_HI(FH), .FAST_SH_LO(FL), .SLOW_SH_HI(SH), .SLOW_SH_LO(SL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .wake_pin_i(wake), .irq_i(irq), .cpu_run_o(cpu_run), .periph_clk_en_o(periph_en),
    .tbt_clk_en_o(tbt_en), .port_hiz_o(hiz), .port_hold_o(hold), .fast_osc_en_o(fosc),
    .slow_osc_en_o(sosc), .sys_clk_slow_o(clk_slow), .rst_req_o(rst_req));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic wake_and_time(input logic lvl, input int hold_n, output int k);
    wake = lvl; slow_tick = 0; k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (k == hold_n + 1) slow_tick = 1;
      if (cpu_run || k > 2000) break;
    end
    slow_tick = 1;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int k, n, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 A", d, 8'h00);
    rd(1, d); chk("R1 B", d, 8'h80);
    chk("R1 run", cpu_run, 1); chk("R1 fosc", fosc, 1); chk("R1 sosc", sosc, 0);
    chk("R1 clk", clk_slow, 0); chk("R1 rstreq", rst_req, 0);
    chk("R8 idle ports", {hiz, hold}, 0);

    // R2 / clock select
    wr(1, 8'hC0); rd(1, d); chk("R2 B both osc", d, 8'hC0); chk("R2 sosc", sosc, 1);
    wr(1, 8'hE0); chk("R2 slow sel", clk_slow, 1); rd(1, d); chk("R2 B rd", d, 8'hE0);
    wr(1, 8'h60); chk("R2 fast off", fosc, 0); chk("R9 legal no rst", rst_req, 0);
    wr(1, 8'hC0); chk("R2 back fast", clk_slow, 0);
    wr(0, 8'h14); rd(0, d); chk("R2 A rd", d, 8'h14);

    // R9 illegal writes
    foreach (d[i]) ; // no-op
    for (int t = 0; t < 3; t++) begin
      logic [7:0] bad;
      bad = (t == 0) ? 8'h00 : (t == 1) ? 8'h40 : 8'hA0;
      wr(1, 8'hC0); wr(0, 8'h14);
      wr(1, bad);
      chk("R9 rst pulse", rst_req, 1);
      rd(0, d); chk("R9 A reset", d, 8'h00);
      rd(1, d); chk("R9 B reset", d, 8'h80);
      @(negedge clk); chk("R9 pulse width", rst_req, 0);
    end

    // R10 light sleep
    wr(1, 8'hC0);
    wr(1, 8'hD0);
    chk("R10 halted", cpu_run, 0); chk("R10 periph", periph_en, 1); chk("R10 tbt", tbt_en, 1);
    wr(0, 8'h80); rd(0, d); chk("R13 write ignored", d, 8'h00); chk("R13 still halted", cpu_run, 0);
    irq = 1; @(negedge clk); irq = 0;
    chk("R10 wake", cpu_run, 1); rd(1, d); chk("R10 bit cleared", d, 8'hC0);

    // R11 timer-only sleep
    wr(1, 8'hC4);
    chk("R11 halted", cpu_run, 0); chk("R11 periph off", periph_en, 0); chk("R11 tbt", tbt_en, 1);
    rd(1, d); chk("R11 B rd", d, 8'hC4);
    irq = 1; @(negedge clk); irq = 0;
    chk("R11 wake", cpu_run, 1); rd(1, d); chk("R11 bit cleared", d, 8'hC0);

    // R12 both set
    wr(1, 8'hD4);
    chk("R12 periph on", periph_en, 1); chk("R12 halted", cpu_run, 0);
    rd(1, d); chk("R12 B rd", d, 8'hD0);
    irq = 1; @(negedge clk); irq = 0;
    chk("R12 wake", cpu_run, 1);

    // deep stop sweep: mode 0 edge->fast, 1 edge->slow, 2 level (slow bit set)->fast
    for (int mode = 0; mode < 3; mode++) begin
      for (int w = 0; w < 4; w++) begin
        logic lvl, rs, keep, slow;
        logic [7:0] a;
        lvl = (mode == 2); rs = (mode != 0); keep = w[0];
        slow = (mode == 1);
        a = 8'h80 | (8'(lvl) << 6) | (8'(rs) << 5) | (8'(keep) << 4) | (8'(w) << 2);
        @(negedge clk); wake = 0;
        wr(0, a);
        chk("R3 halted", cpu_run, 0); chk("R3 clocks", {periph_en, tbt_en}, 0);
        chk("R3 osc off", {fosc, sosc}, 0);
        rd(0, d); chk("R3 A rd", d, a);
        chk("R8 hiz", hiz, !keep); chk("R8 hold", hold, keep);
        if (!lvl) begin
          wake = 1;
          repeat (3) @(negedge clk);
          chk("R4 rise ignored", cpu_run, 0);
        end else begin
          repeat (3) @(negedge clk);
          chk("R5 low holds stop", cpu_run, 0);
        end
        n = (w[0] ? 1 : 3) << (slow ? (w[1] ? SL : SH) : (w[1] ? FL : FH));
        exp = n + 3 + (slow ? 3 : 0);
        wake_and_time(lvl ? 1'b1 : 1'b0, 3, k);
        chk(slow ? "R7 slow warmup" : "R7 fast warmup", k, exp);
        chk(lvl ? "R5 level fast return" : "R6 return clock", clk_slow, slow);
        rd(1, d); chk("R6 B clk bit", d[5], slow);
        chk("R6 osc on", slow ? sosc : fosc, 1);
        rd(0, d); chk("R7 stop cleared", d[7], 0);
        chk("R8 ports released", {hiz, hold}, 0);
        wake = 1;
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule